// File: doc/BRIEF.md
# Alternating-Interval Compare Waveform Generator

This block produces a square wave whose low and high widths are set independently, without ever clearing its time base. A free-running up-counter advances on each prescale tick. A compare register holds the next event time. Whenever a tick carries the counter onto that value, the block does three things at the same edge: it moves the wave to its next level, it pulses a one-cycle match strobe, and it adds the next interval to the compare register. The interval used alternates between a low-time value and a high-time value.

Timing is measured in ticks, so the output widths follow whatever prescale rate drives the tick input. All arithmetic wraps at the counter width. An interval can therefore run across a counter rollover with no special handling. The match strobe is meant for downstream timers that must stay aligned to the wave edges. The interval and start inputs are plain levels that the block samples when it needs them, so no handshake is involved.

Top module: `altcmp_gen`

## Requirements
- R1: While the synchronous reset is high at a clock edge, the block forces `wave_o` low, `match_o` low and the counter to 0. At the same edge it loads the compare register from `init_cmp_i` and selects the low interval as the next one to add.
- R2: The counter increments by one, modulo 2^CW, only at edges where `tick_i` is high. At all other edges it holds its value.
- R3: `match_o` is high for the one cycle that follows a clock edge at which a tick moves the counter onto the compare value. At no other time is it high. After reset with a nonzero start value S, the first strobe follows the S-th tick.
- R4: The first match after reset leaves `wave_o` low and adds `low_iv_i` to the compare register.
- R5: A match that follows an addition of the low interval sets `wave_o` to 1 and adds `high_iv_i`. The wave then stays high for exactly the high-interval number of ticks.
- R6: A match that follows an addition of the high interval clears `wave_o` to 0 and adds `low_iv_i`. The wave then stays low for exactly the low-interval number of ticks.
- R7: The compare addition wraps modulo 2^CW. An interval that crosses a counter rollover still produces its match after the programmed number of ticks.
- R8: `wave_o` changes level only in a cycle in which `match_o` is high.
- R9: The interval inputs are sampled only at a match edge. Changes between matches affect only the next addition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Prescale tick; the counter advances on edges where it is high |
| init_cmp_i | input | CW (16) | Compare value loaded during reset |
| low_iv_i | input | CW (16) | Ticks the wave spends low; must be at least 1 |
| high_iv_i | input | CW (16) | Ticks the wave spends high; must be at least 1 |
| wave_o | output | 1 | Generated square wave |
| match_o | output | 1 | One-cycle strobe on each compare match |

## Verification
The properties assume that both interval inputs are nonzero whenever a match can sample them. A zero interval would leave the compare value on the current count, and the next match would then come only after a full counter wrap. The properties also assume that the start value is held steady during reset. Random stimulus draws every interval from 1 to 40 and changes it only now and then between matches. It draws the start value from 1 to 60 and applies it before reset is raised. Directed runs add a sparse tick pattern and one interval pair large enough to force the compare register across the 16-bit rollover.

// File: rtl/altcmp_pkg.sv
package altcmp_pkg;
  // Which interval the next match will add to the compare register.
  typedef enum logic {
    PH_LOW_NEXT  = 1'b0,
    PH_HIGH_NEXT = 1'b1
  } phase_e;
endpackage

// File: rtl/altcmp_counter.sv
module altcmp_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          tick_i,
  input  logic [CW-1:0] cmp_i,
  output logic [CW-1:0] cnt_o,
  output logic          hit_o
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;

  assign cnt_inc = cnt_q + ONE;

  always_ff @(posedge clk_i) begin
    if (rst_i)       cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_inc;
  end

  // A hit is the tick that lands the counter on the compare value.
  assign hit_o = tick_i & (cnt_inc == cmp_i);
  assign cnt_o = cnt_q;
endmodule

// File: rtl/altcmp_advance.sv
module altcmp_advance
  import altcmp_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          hit_i,
  input  logic [CW-1:0] init_cmp_i,
  input  logic [CW-1:0] low_iv_i,
  input  logic [CW-1:0] high_iv_i,
  output logic [CW-1:0] cmp_o,
  output phase_e        phase_o
);
  logic [CW-1:0] cmp_q;
  logic [CW-1:0] step;
  phase_e        phase_q;

  assign step = (phase_q == PH_LOW_NEXT) ? low_iv_i : high_iv_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cmp_q   <= init_cmp_i;
      phase_q <= PH_LOW_NEXT;
    end else if (hit_i) begin
      cmp_q   <= cmp_q + step;  // wraps at CW bits
      phase_q <= (phase_q == PH_LOW_NEXT) ? PH_HIGH_NEXT : PH_LOW_NEXT;
    end
  end

  assign cmp_o   = cmp_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/altcmp_wave.sv
module altcmp_wave
  import altcmp_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_i,
  input  logic   hit_i,
  input  phase_e phase_i,
  output logic   wave_o,
  output logic   match_o
);
  logic wave_q;
  logic match_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      wave_q  <= 1'b0;
      match_q <= 1'b0;
    end else begin
      match_q <= hit_i;
      // After a low-interval add the match sets; after a high add it clears.
      if (hit_i) wave_q <= (phase_i == PH_HIGH_NEXT);
    end
  end

  assign wave_o  = wave_q;
  assign match_o = match_q;
endmodule

// File: rtl/altcmp_gen.sv
module altcmp_gen
  import altcmp_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          tick_i,
  input  logic [CW-1:0] init_cmp_i,
  input  logic [CW-1:0] low_iv_i,
  input  logic [CW-1:0] high_iv_i,
  output logic          wave_o,
  output logic          match_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cmp_q;
  logic          hit;
  phase_e        phase_q;

  altcmp_counter #(.CW(CW)) u_cnt (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .tick_i(tick_i),
    .cmp_i (cmp_q),
    .cnt_o (cnt_q),
    .hit_o (hit)
  );

  altcmp_advance #(.CW(CW)) u_adv (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .hit_i     (hit),
    .init_cmp_i(init_cmp_i),
    .low_iv_i  (low_iv_i),
    .high_iv_i (high_iv_i),
    .cmp_o     (cmp_q),
    .phase_o   (phase_q)
  );

  altcmp_wave u_wave (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .hit_i  (hit),
    .phase_i(phase_q),
    .wave_o (wave_o),
    .match_o(match_o)
  );
endmodule

// File: rtl/altcmp_chk.sv
module altcmp_chk
  import altcmp_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic          tick_i,
  input logic          wave_o,
  input logic          match_o,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] cmp_q,
  input phase_e        phase_q
);
  p_reset_quiet_r1: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!wave_o && !match_o));

  p_hold_without_tick_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$past(tick_i)) |-> $stable(cnt_q));

  p_strobe_needs_tick_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    match_o |-> $past(tick_i));

  p_strobe_at_compare_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    match_o |-> (cnt_q == $past(cmp_q)));

  p_set_after_low_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (match_o && !$past(rst_i) && $past(phase_q) == PH_HIGH_NEXT) |-> wave_o);

  p_clear_after_high_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (match_o && !$past(rst_i) && $past(phase_q) == PH_LOW_NEXT) |-> !wave_o);

  p_wave_moves_on_strobe_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$stable(wave_o)) |-> match_o);

  p_cmp_moves_on_strobe_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$stable(cmp_q)) |-> match_o);
endmodule

bind altcmp_gen altcmp_chk #(.CW(CW)) u_chk (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .tick_i (tick_i),
  .wave_o (wave_o),
  .match_o(match_o),
  .cnt_q  (cnt_q),
  .cmp_q  (cmp_q),
  .phase_q(phase_q)
);

// File: tb/tb_altcmp_gen.sv
module tb_altcmp_gen;
  logic        clk = 1'b0;
  logic        rst_i;
  logic        tick_i;
  logic [15:0] init_cmp_i, low_iv_i, high_iv_i;
  logic        wave_o, match_o;

  always #10 clk = ~clk;  // 50 MHz

  altcmp_gen #(.CW(16)) dut (
    .clk_i(clk), .rst_i(rst_i), .tick_i(tick_i),
    .init_cmp_i(init_cmp_i), .low_iv_i(low_iv_i), .high_iv_i(high_iv_i),
    .wave_o(wave_o), .match_o(match_o)
  );

  int checks = 0, failures = 0;
  bit timed_out = 0;

  // reference state derived from the requirements
  logic [15:0] m_cnt, m_cmp;
  bit m_high_next, m_wave, m_match, prev_wave;
  int edge_n, n_strobes, first_strobe, last_strobe;

  function automatic logic [15:0] wrap_add(logic [15:0] a, logic [15:0] b);
    return a + b;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Inputs are already set; predict the next edge, then sample at negedge.
  task automatic cycle();
    bit hit;
    if (rst_i) begin
      m_cnt = 0; m_cmp = init_cmp_i; m_high_next = 0; m_wave = 0; m_match = 0;
      edge_n = 0; n_strobes = 0; first_strobe = 0; last_strobe = 0;
    end else begin
      hit = tick_i && (wrap_add(m_cnt, 16'd1) == m_cmp);
      if (tick_i) m_cnt = wrap_add(m_cnt, 16'd1);
      if (hit) begin
        m_wave = m_high_next;
        m_cmp = wrap_add(m_cmp, m_high_next ? high_iv_i : low_iv_i);
        m_high_next = !m_high_next;
      end
      m_match = hit;
      edge_n++;
    end
    prev_wave = wave_o;
    @(negedge clk);
    check(match_o === m_match, "R3/R9 match", int'(match_o), int'(m_match));
    if (m_wave) check(wave_o === m_wave, "R5 wave", int'(wave_o), int'(m_wave));
    else        check(wave_o === m_wave, "R6 wave", int'(wave_o), int'(m_wave));
    if (!rst_i && wave_o !== prev_wave)
      check(match_o === 1'b1, "R8 wave change without strobe", int'(match_o), 1);
    if (!rst_i && match_o) begin
      n_strobes++; last_strobe = edge_n;
      if (first_strobe == 0) first_strobe = edge_n;
    end
  endtask

  task automatic do_reset(logic [15:0] init, logic [15:0] lo, logic [15:0] hi);
    init_cmp_i = init; low_iv_i = lo; high_iv_i = hi; tick_i = 1'b0; rst_i = 1'b1;
    cycle(); cycle();
    check(!wave_o && !match_o, "R1 reset outputs", int'({wave_o, match_o}), 0);
    rst_i = 1'b0;
  endtask

  task automatic main();
    void'($urandom(32'h5EED_0042));
    @(negedge clk);
    // R4/R5/R6 directed: start 5, low 3, high 7, tick every cycle
    do_reset(16'd5, 16'd3, 16'd7);
    tick_i = 1'b1;
    for (int i = 0; i < 40; i++) cycle();
    check(first_strobe == 5, "R4 first strobe edge", first_strobe, 5);
    check(n_strobes == 8, "R5 R6 strobe count", n_strobes, 8);
    check(last_strobe == 38, "R6 last strobe edge", last_strobe, 38);

    // R2: tick on every second edge, start 4 -> strobe at edge 8
    do_reset(16'd4, 16'd2, 16'd2);
    for (int i = 1; i <= 12; i++) begin
      tick_i = (i % 2 == 0);
      cycle();
    end
    check(first_strobe == 8, "R2 gated tick first strobe", first_strobe, 8);

    // R7: compare wraps; strobes at 3, 65523, 65555
    do_reset(16'd3, 16'hFFF0, 16'h0020);
    tick_i = 1'b1;
    for (int i = 0; i < 65560; i++) cycle();
    check(n_strobes == 3, "R7 strobe count across wrap", n_strobes, 3);
    check(last_strobe == 65555, "R7 strobe after rollover", last_strobe, 65555);

    // Random: sparse ticks, intervals changed between matches (R9), rare resets (R1)
    do_reset(16'd10, 16'd4, 16'd9);
    for (int i = 0; i < 20000; i++) begin
      tick_i = ($urandom % 10) < 7;
      if ($urandom % 20 == 0) low_iv_i  = 16'(1 + $urandom % 40);
      if ($urandom % 20 == 0) high_iv_i = 16'(1 + $urandom % 40);
      if ($urandom % 2000 == 0) begin
        do_reset(16'(1 + $urandom % 60), low_iv_i, high_iv_i);
        tick_i = 1'b1;
      end
      cycle();
    end
  endtask

  initial begin
    rst_i = 1'b1; tick_i = 1'b0;
    init_cmp_i = 16'd1; low_iv_i = 16'd1; high_iv_i = 16'd1;
    fork
      main();
      begin
        repeat (190000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    if (timed_out) begin
      failures++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule